// File: doc/BRIEF.md
# Flow-Through Burst SRAM

This block models a small synchronous static RAM that serves bursts of four words. Address, control and write data are captured on each rising clock edge. Read data for the captured address is driven in the same cycle, with no output register. A burst is opened by one of two active-low start strobes: a host-side one and a controller-side one. An active-low step input then walks a 2-bit burst count, and the low two address bits follow either an interleaved (XOR) order or a linear wrap order. The order is chosen at burst start.

Three chip enables gate selection: a primary active-low enable, an active-high auxiliary enable and an active-low auxiliary enable. Writes are decoded from a write-all input, a lane-gate input and one active-low enable per lane. The data output is paired with a separate drive-enable output, and the RAM stays quiet whenever that enable is low. A sleep input puts the RAM into a retention state. The RAM then needs recovery cycles before it accepts accesses again.

Top module: `fburst_sram`

## Requirements
- R1: An accepted host start with all enables active, and with `out_en_n` low, drives `q_en_o`=1 and `q_o` = the word at `addr_i` in the cycle that follows the capturing edge.
- R2: A burst started with `order_ilv`=1 addresses low bits `s XOR k`, where `s` is the start low two bits and `k` counts 0,1,2,3 with one step per edge that has `step_n` low. The count wraps after the fourth word, and the upper address bits never change.
- R3: A burst started with `order_ilv`=0 addresses low bits `(s + k) mod 4`, with the upper address bits unchanged.
- R4: `order_ilv` is sampled only at a burst start. Changing it during a burst has no effect on the order.
- R5: An edge with both strobes high and `step_n` high keeps the current address (suspend). Reads repeat the same word.
- R6: A host strobe is ignored while `en_main_n` is high. With the controller strobe high, that edge behaves as a step or suspend cycle of the running burst.
- R7: The RAM deselects on a controller start while any enable is inactive, or on a host start with `en_main_n` low and an auxiliary enable inactive. It also starts deselected after reset. While deselected, `q_en_o`=0 and `q_o`=0, and step or suspend cycles write nothing. Only a start strobe reselects the RAM.
- R8: A host start is a read in its own cycle even when write inputs are active, and memory is unchanged by it.
- R9: `wr_all_n`=0 writes all four lanes. Otherwise `lane_gate_n`=0 writes each lane whose `lane_n` bit is 0, where bit i selects data bits [8i+7:8i] (bit 0 is the lowest byte). With no lane selected, the cycle is a read.
- R10: `q_en_o`=0 and `q_o`=0 in every write cycle and whenever `out_en_n` is high.
- R11: After two consecutive edges that sample `sleep_i` high, the RAM is asleep, and the access on the second of those edges is ignored. While asleep, accesses are ignored, outputs are quiet, burst and selection are cleared, and contents are kept.
- R12: The edge that first samples `sleep_i` low, and the edge after it, ignore accesses. The second edge after that release edge accepts one.
- R13: Auxiliary enables are not looked at in step or suspend cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr_i | input | ADDR_W | Word address, captured at a start |
| strt_host_n | input | 1 | Host-side burst start, active low |
| strt_ctl_n | input | 1 | Controller-side burst start, active low |
| step_n | input | 1 | Advance burst count, active low |
| en_main_n | input | 1 | Primary chip enable, active low |
| en_aux | input | 1 | Auxiliary chip enable, active high |
| en_aux_n | input | 1 | Auxiliary chip enable, active low |
| wr_all_n | input | 1 | Write every lane, active low |
| lane_gate_n | input | 1 | Qualifies per-lane enables, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Output drive enable for reads, active low |
| order_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| sleep_i | input | 1 | Retention sleep request |
| d_i | input | LANES*LANE_W | Write data |
| q_o | output | LANES*LANE_W | Read data, zero when not driven |
| q_en_o | output | 1 | Drive enable for q_o |

## Verification
A wrong burst count or a stale order flag shows up in the very next read cycle, because the wrong word appears on `q_o` with no pipeline in between. A selection bit that is wrongly set or cleared shows at once on `q_en_o`. A write that lands where it should not stays hidden until that location is read again, so the stimulus rereads every region it disturbs. A sleep or recovery counter that is off by one moves the first accepted access by one edge. The reread after wake-up exposes that shift.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    typedef enum logic [2:0] {
        CYC_LOAD_RD,
        CYC_LOAD_WR,
        CYC_DESEL,
        CYC_STEP,
        CYC_HOLD
    } cyc_kind_e;

endpackage

// File: rtl/fbs_burst_order.sv
module fbs_burst_order #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             ilv_i,
    output logic [CNT_W-1:0] pos_o
);

    always_comb begin
        if (ilv_i) begin
            pos_o = start_i ^ count_i;
        end else begin
            pos_o = start_i + count_i;
        end
    end

endmodule

// File: rtl/fbs_cycle_decode.sv
module fbs_cycle_decode
    import fbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             strt_host_n,
    input  logic             strt_ctl_n,
    input  logic             step_n,
    input  logic             en_main_n,
    input  logic             en_aux,
    input  logic             en_aux_n,
    input  logic             wr_all_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_n,
    output cyc_kind_e        kind_o,
    output logic [LANES-1:0] lane_we_o
);

    logic enables_ok;
    logic host_start;

    always_comb begin
        enables_ok = !en_main_n && en_aux && !en_aux_n;
        host_start = !strt_host_n && !en_main_n;

        if (host_start) begin
            kind_o = enables_ok ? CYC_LOAD_RD : CYC_DESEL;
        end else if (!strt_ctl_n) begin
            kind_o = enables_ok ? CYC_LOAD_WR : CYC_DESEL;
        end else if (!step_n) begin
            kind_o = CYC_STEP;
        end else begin
            kind_o = CYC_HOLD;
        end

        if (!wr_all_n) begin
            lane_we_o = '1;
        end else if (!lane_gate_n) begin
            lane_we_o = ~lane_n;
        end else begin
            lane_we_o = '0;
        end
    end

endmodule

// File: rtl/fbs_sleep_ctl.sv
module fbs_sleep_ctl #(
    parameter int SLEEP_CYC = 2,
    parameter int WAKE_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    output logic accept_o,
    output logic clear_o,
    output logic asleep_o
);

    localparam int MAXC = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC) + 1;

    typedef struct packed {
        logic          asleep;
        logic [CW-1:0] ent;
        logic [CW-1:0] wake;
    } slp_t;

    slp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        accept_o = 1'b0;
        clear_o  = 1'b0;
        if (s_q.asleep) begin
            s_d.ent = '0;
            if (!sleep_i) begin
                s_d.asleep = 1'b0;
                s_d.wake   = CW'(WAKE_CYC - 1);
            end
        end else begin
            accept_o = (s_q.wake == '0);
            if (s_q.wake != '0) begin
                s_d.wake = s_q.wake - CW'(1);
            end
            if (sleep_i) begin
                if (s_q.ent == CW'(SLEEP_CYC - 1)) begin
                    s_d.asleep = 1'b1;
                    s_d.ent    = '0;
                    clear_o    = 1'b1;
                    accept_o   = 1'b0;
                end else begin
                    s_d.ent = s_q.ent + CW'(1);
                end
            end else begin
                s_d.ent = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign asleep_o = s_q.asleep;

endmodule

// File: rtl/fbs_lane_array.sv
module fbs_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    we_i,
    input  logic [LANES-1:0]        lane_we_i,
    input  logic [ADDR_W-1:0]       waddr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]       raddr_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int WORDS = 2 ** ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [WORDS];

        always_ff @(posedge clk) begin
            if (we_i && lane_we_i[g]) begin
                bank[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = bank[raddr_i];
    end

endmodule

// File: rtl/fburst_sram.sv
module fburst_sram
    import fbs_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int LANE_W    = 8,
    parameter int LANES     = 4,
    parameter int SLEEP_CYC = 2,
    parameter int WAKE_CYC  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    strt_host_n,
    input  logic                    strt_ctl_n,
    input  logic                    step_n,
    input  logic                    en_main_n,
    input  logic                    en_aux,
    input  logic                    en_aux_n,
    input  logic                    wr_all_n,
    input  logic                    lane_gate_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    out_en_n,
    input  logic                    order_ilv,
    input  logic                    sleep_i,
    input  logic [LANES*LANE_W-1:0] d_i,
    output logic [LANES*LANE_W-1:0] q_o,
    output logic                    q_en_o
);

    localparam int DATA_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic              ilv;
        logic [BURST_W-1:0] cnt;
        logic [ADDR_W-1:0] base;
    } st_t;

    st_t st_d, st_q;

    cyc_kind_e           kind;
    logic [LANES-1:0]    lane_we;
    logic                accept;
    logic                clear;
    logic                asleep;
    logic [BURST_W-1:0]  cur_lo, nxt_lo;
    logic [ADDR_W-1:0]   cur_addr, nxt_addr, waddr;
    logic                wen;
    logic [DATA_W-1:0]   rdata;

    fbs_cycle_decode #(.LANES(LANES)) u_dec (
        .strt_host_n (strt_host_n),
        .strt_ctl_n  (strt_ctl_n),
        .step_n      (step_n),
        .en_main_n   (en_main_n),
        .en_aux      (en_aux),
        .en_aux_n    (en_aux_n),
        .wr_all_n    (wr_all_n),
        .lane_gate_n (lane_gate_n),
        .lane_n      (lane_n),
        .kind_o      (kind),
        .lane_we_o   (lane_we)
    );

    fbs_sleep_ctl #(.SLEEP_CYC(SLEEP_CYC), .WAKE_CYC(WAKE_CYC)) u_slp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_i  (sleep_i),
        .accept_o (accept),
        .clear_o  (clear),
        .asleep_o (asleep)
    );

    fbs_burst_order #(.CNT_W(BURST_W)) u_ord_cur (
        .start_i (st_q.base[BURST_W-1:0]),
        .count_i (st_q.cnt),
        .ilv_i   (st_q.ilv),
        .pos_o   (cur_lo)
    );

    fbs_burst_order #(.CNT_W(BURST_W)) u_ord_nxt (
        .start_i (st_q.base[BURST_W-1:0]),
        .count_i (st_q.cnt + BURST_W'(1)),
        .ilv_i   (st_q.ilv),
        .pos_o   (nxt_lo)
    );

    assign cur_addr = {st_q.base[ADDR_W-1:BURST_W], cur_lo};
    assign nxt_addr = {st_q.base[ADDR_W-1:BURST_W], nxt_lo};

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        wen     = 1'b0;
        waddr   = cur_addr;
        if (clear) begin
            st_d.sel = 1'b0;
            st_d.cnt = '0;
        end else if (accept) begin
            unique case (kind)
                CYC_LOAD_RD, CYC_LOAD_WR: begin
                    st_d.sel  = 1'b1;
                    st_d.base = addr_i;
                    st_d.cnt  = '0;
                    st_d.ilv  = order_ilv;
                    waddr     = addr_i;
                    wen       = (kind == CYC_LOAD_WR) && (|lane_we);
                end
                CYC_DESEL: begin
                    st_d.sel = 1'b0;
                end
                CYC_STEP: begin
                    if (st_q.sel) begin
                        st_d.cnt = st_q.cnt + BURST_W'(1);
                        waddr    = nxt_addr;
                        wen      = |lane_we;
                    end
                end
                CYC_HOLD: begin
                    wen = st_q.sel && (|lane_we);
                end
                default: begin
                    st_d.sel = st_q.sel;
                end
            endcase
            st_d.wr = wen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fbs_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk       (clk),
        .we_i      (wen),
        .lane_we_i (lane_we),
        .waddr_i   (waddr),
        .wdata_i   (d_i),
        .raddr_i   (cur_addr),
        .rdata_o   (rdata)
    );

    assign q_en_o = st_q.sel && !st_q.wr && !out_en_n && !asleep;
    assign q_o    = q_en_o ? rdata : '0;

endmodule

// File: rtl/fbs_sram_chk.sv
module fbs_sram_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strt_host_n,
    input logic              strt_ctl_n,
    input logic              step_n,
    input logic              en_main_n,
    input logic              en_aux,
    input logic              q_en,
    input logic              sel_q,
    input logic              wr_q,
    input logic              ilv_q,
    input logic              asleep,
    input logic              accept,
    input logic [ADDR_W-1:0] cur_addr
);

    // R10: a write cycle never drives the bus
    p_write_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> !q_en);

    // R11: asleep means quiet outputs
    p_sleep_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !q_en);

    // R8: host start never writes
    p_host_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !strt_host_n && !en_main_n) |=> !wr_q);

    // R7: controller start with the high enable off deselects
    p_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && strt_host_n && !strt_ctl_n && !en_aux) |=> (!q_en && !sel_q));

    // R5: suspend keeps the address
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel_q && strt_host_n && strt_ctl_n && step_n) |=> $stable(cur_addr));

    // R4: order flag only changes at a start
    p_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && strt_host_n && strt_ctl_n) |=> $stable(ilv_q));

    // R12: the edge after release is still ignored
    p_wake_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> !accept);

endmodule

bind fburst_sram fbs_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strt_host_n (strt_host_n),
    .strt_ctl_n  (strt_ctl_n),
    .step_n      (step_n),
    .en_main_n   (en_main_n),
    .en_aux      (en_aux),
    .q_en        (q_en_o),
    .sel_q       (st_q.sel),
    .wr_q        (st_q.wr),
    .ilv_q       (st_q.ilv),
    .asleep      (asleep),
    .accept      (accept),
    .cur_addr    (cur_addr)
);

// File: tb/fburst_sram_tb.sv
module fburst_sram_tb;

    localparam int AW = 6;
    localparam int NW = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic        strt_host_n = 1, strt_ctl_n = 1, step_n = 1;
    logic        en_main_n = 0, en_aux = 1, en_aux_n = 0;
    logic        wr_all_n = 1, lane_gate_n = 1;
    logic [3:0]  lane_n = 4'hF;
    logic        out_en_n = 0, order_ilv = 1, sleep_i = 0;
    logic [31:0] d_i = '0;
    logic [31:0] q_o;
    logic        q_en_o;

    always #4 clk = ~clk;

    fburst_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .strt_host_n(strt_host_n), .strt_ctl_n(strt_ctl_n), .step_n(step_n),
        .en_main_n(en_main_n), .en_aux(en_aux), .en_aux_n(en_aux_n),
        .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n), .lane_n(lane_n),
        .out_en_n(out_en_n), .order_ilv(order_ilv), .sleep_i(sleep_i),
        .d_i(d_i), .q_o(q_o), .q_en_o(q_en_o)
    );

    // reference state
    logic [31:0] ref_mem [NW];
    bit    m_sel = 0, m_wr = 0, m_ilv = 0, m_asleep = 0;
    int    m_base = 0, m_cnt = 0, m_hi = 0, m_wake = 0;
    int    total = 0, bad = 0;
    bit    finished = 0;
    string req = "R7";

    function automatic int cur_word();
        int lo;
        lo = m_base % 4;
        if (m_ilv) lo = lo ^ m_cnt;
        else       lo = (lo + m_cnt) % 4;
        return (m_base / 4) * 4 + lo;
    endfunction

    task automatic put_word(int a, logic [3:0] mask);
        for (int i = 0; i < 4; i++)
            if (mask[i]) ref_mem[a][8*i +: 8] = d_i[8*i +: 8];
        m_wr = 1;
    endtask

    task automatic model_edge();
        bit acc, host, ok;
        logic [3:0] mask;
        acc = 1;
        m_wr = 0;
        if (m_asleep) begin
            acc = 0;
            if (!sleep_i) begin m_asleep = 0; m_wake = 1; end
        end else begin
            if (m_wake > 0) begin acc = 0; m_wake = m_wake - 1; end
            if (sleep_i) begin
                m_hi = m_hi + 1;
                if (m_hi == 2) begin
                    m_hi = 0; m_asleep = 1; acc = 0; m_sel = 0; m_cnt = 0;
                end
            end else m_hi = 0;
        end
        if (!acc) return;
        host = !strt_host_n && !en_main_n;
        ok   = !en_main_n && en_aux && !en_aux_n;
        if (!wr_all_n)         mask = 4'hF;
        else if (!lane_gate_n) mask = ~lane_n;
        else                   mask = 4'h0;
        if (host || !strt_ctl_n) begin
            if (ok) begin
                m_sel = 1; m_base = int'(addr_i); m_cnt = 0; m_ilv = order_ilv;
                if (!host && mask != 0) put_word(int'(addr_i), mask);
            end else m_sel = 0;
        end else if (m_sel) begin
            if (!step_n) m_cnt = (m_cnt + 1) % 4;
            if (mask != 0) put_word(cur_word(), mask);
        end
    endtask

    task automatic compare();
        bit exp_en;
        logic [31:0] exp_q;
        exp_en = m_sel && !m_wr && !out_en_n && !m_asleep;
        exp_q  = exp_en ? ref_mem[cur_word()] : 32'h0;
        total++;
        if (q_en_o !== exp_en) begin
            bad++;
            $display("FAIL %s q_en_o actual=%0b expected=%0b t=%0t", req, q_en_o, exp_en, $time);
        end
        total++;
        if (q_o !== exp_q) begin
            bad++;
            $display("FAIL %s q_o actual=%h expected=%h t=%0t", req, q_o, exp_q, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        strt_host_n = 1; strt_ctl_n = 1; step_n = 1;
        en_main_n = 0; en_aux = 1; en_aux_n = 0;
        wr_all_n = 1; lane_gate_n = 1; lane_n = 4'hF; out_en_n = 0;
    endtask

    task automatic host_start(int a, bit ilv);
        addr_i = AW'(a); order_ilv = ilv; strt_host_n = 0;
        tick();
        strt_host_n = 1;
    endtask

    task automatic steps(int n);
        step_n = 0;
        for (int i = 0; i < n; i++) tick();
        step_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        req = "R7"; compare();               // reset: deselected, quiet
        rst_n = 1;

        // fill every word through controller starts (R9 write-all)
        req = "R9";
        for (int a = 0; a < NW; a++) begin
            strt_ctl_n = 0; wr_all_n = 0; addr_i = AW'(a);
            d_i = (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F00;
            tick();
        end
        quiet();

        req = "R1";
        host_start(5, 1); host_start(30, 0); host_start(63, 1); tick();

        req = "R2";                          // interleaved from every offset, with wrap
        for (int o = 0; o < 4; o++) begin host_start(8 + o, 1); steps(4); end

        req = "R3";                          // linear from every offset, with wrap
        for (int o = 0; o < 4; o++) begin host_start(20 + o, 0); steps(4); end

        req = "R4";
        host_start(33, 1); order_ilv = 0; steps(3);
        host_start(46, 0); order_ilv = 1; steps(3);

        req = "R5";
        host_start(42, 0); steps(1); tick(); tick(); steps(1); tick();

        req = "R6";
        strt_host_n = 0; en_main_n = 1; addr_i = 6'd5; tick();
        step_n = 0; tick(); step_n = 1;
        quiet(); tick();

        req = "R8";
        addr_i = 6'd50; strt_host_n = 0; wr_all_n = 0; d_i = 32'hFFFF_FFFF; tick();
        quiet(); tick(); host_start(50, 1);

        req = "R9";
        addr_i = 6'd12; order_ilv = 0; strt_ctl_n = 0; lane_gate_n = 0; lane_n = 4'b1010;
        d_i = 32'h1122_3344; tick();
        strt_ctl_n = 1; step_n = 0; lane_n = 4'b0110; d_i = 32'h5566_7788; tick();
        lane_gate_n = 1; wr_all_n = 0; d_i = 32'h99AA_BBCC; tick();
        wr_all_n = 1; lane_gate_n = 0; lane_n = 4'hF; tick();
        quiet(); host_start(12, 0); steps(3);

        req = "R13";
        host_start(16, 1); en_aux = 0; en_aux_n = 1; steps(3); tick(); quiet();

        req = "R7";
        addr_i = 6'd40; strt_ctl_n = 0; en_aux = 0; tick();
        quiet(); wr_all_n = 0; d_i = 32'hDEAD_BEEF; steps(2); tick();
        quiet(); addr_i = 6'd41; strt_host_n = 0; en_aux_n = 1; tick();
        quiet(); tick();
        host_start(40, 0); steps(3);

        req = "R10";
        host_start(3, 1); out_en_n = 1; tick(); out_en_n = 0; tick();
        wr_all_n = 0; d_i = 32'h0BAD_F00D; tick(); quiet(); tick();

        req = "R11";
        host_start(7, 0);
        sleep_i = 1; tick(); tick();
        strt_ctl_n = 0; wr_all_n = 0; addr_i = 6'd9; d_i = 32'h1357_9BDF;
        tick(); tick(); tick();

        req = "R12";
        sleep_i = 0; tick(); tick(); tick();
        quiet(); tick();
        host_start(9, 1); host_start(7, 0); steps(2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule